// File: doc/BRIEF.md
# Load Data Width Converter

This block takes the raw bytes returned by a memory read and turns them into one destination register element. It keeps only the bytes that belong to the access size. It reverses their byte order when the instruction's byte-reverse request and the processor's endian mode call for it. It then fits the value to the destination element width. The fit is either a plain zero-extend or truncate, or a signed or unsigned saturating narrow.

The unit is a single pipeline stage. A request presented with `in_valid` produces a registered result, with `out_valid`, on the next clock. The unit also reports whether the memory-side element width is narrower than the access size. That combination has no defined result, so a later stage can act on the flag. The result value itself is still computed.

Size codes are shared by all width inputs: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 is 64 bits.

Top module: `ldconv_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low one clock after a cycle with `in_valid` low. Reset clears `out_valid`, `out_data` and `out_undef` to zero.
- R2: Only the low bytes of `raw_data` selected by `op_size` enter the conversion. Bytes above that size have no effect on `out_data`.
- R3: Byte order is reversed within the access size when `byte_rev` XNOR `little_endian` is 1. With `byte_rev`=0 and `little_endian`=1, the order is kept.
- R4: With `sat_en`=0, the access-size value is zero-extended or truncated to the width given by `dst_size`. Every `out_data` bit above that width is 0.
- R5: With `sat_en`=1 and `sat_signed`=0, the zero-extended value is clamped to at most 2^D-1, where D is the destination width.
- R6: With `sat_en`=1 and `sat_signed`=1, the value is sign-extended from the access size and clamped to the range -2^(D-1) to 2^(D-1)-1. The result is returned as a D-bit two's complement field with zeros above it.
- R7: In saturating mode, when the destination width is at least the access size, the value is only extended: zero-extended if unsigned, sign-extended to D bits if signed.
- R8: `out_undef` is 1 when `mem_size` is a smaller code than `op_size`, and 0 otherwise. The conversion of `out_data` proceeds normally in both cases.
- R9: While `in_valid` is low, `out_data` and `out_undef` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| raw_data | input | DATA_W | Raw memory read, access bytes in the low end |
| op_size | input | SZ_W | Access size code |
| byte_rev | input | 1 | Instruction requests byte-reversed access |
| little_endian | input | 1 | Processor is in little-endian mode |
| dst_size | input | SZ_W | Destination element width code |
| mem_size | input | SZ_W | Memory-side element width code |
| sat_en | input | 1 | Saturating narrow enable |
| sat_signed | input | 1 | 1 selects signed saturation, 0 unsigned |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | DATA_W | Converted element, zero above its width |
| out_undef | output | 1 | Memory-side width narrower than access size |

## Verification
The assertions assume that every size code is one of the four defined values, and that the control inputs are settled at the sampling edge whenever `in_valid` is high. The stimulus uses only codes 0 to 3. It changes inputs only on the falling clock edge, and it holds `in_valid` low between requests so that the hold behaviour can be observed. The vectors cover truncation, extension and both clamp bounds of each saturation polarity. Corner values sit exactly on the signed minimum, one below it, and one above the unsigned maximum.

// File: rtl/ldconv_pkg.sv
package ldconv_pkg;
  localparam int unsigned BYTE_W = 8;

  // number of width codes for a given datapath width (8 bits upward)
  function automatic int unsigned num_sizes(input int unsigned data_w);
    return $clog2(data_w / BYTE_W) + 1;
  endfunction
endpackage

// File: rtl/ldconv_swap.sv
module ldconv_swap #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SZ_W   = 2
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [SZ_W-1:0]   op_sz,
  input  logic              do_swap,
  output logic [DATA_W-1:0] val
);
  import ldconv_pkg::*;
  localparam int unsigned NSIZES = num_sizes(DATA_W);

  logic [DATA_W-1:0] plain_a [NSIZES];
  logic [DATA_W-1:0] rev_a   [NSIZES];

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int unsigned NB = 1 << k;
    localparam int unsigned W  = NB * BYTE_W;
    logic [W-1:0] rev_w;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev_w[b*BYTE_W +: BYTE_W] = raw[(NB-1-b)*BYTE_W +: BYTE_W];
    end
    assign plain_a[k] = DATA_W'(raw[W-1:0]);
    assign rev_a[k]   = DATA_W'(rev_w);
  end

  assign val = do_swap ? rev_a[op_sz] : plain_a[op_sz];
endmodule

// File: rtl/ldconv_narrow.sv
module ldconv_narrow #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SZ_W   = 2
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SZ_W-1:0]   op_sz,
  input  logic [SZ_W-1:0]   dst_sz,
  input  logic              sat_en,
  input  logic              sat_sgn,
  output logic [DATA_W-1:0] res
);
  import ldconv_pkg::*;
  localparam int unsigned NSIZES = num_sizes(DATA_W);

  logic [DATA_W-1:0] mask_a [NSIZES];
  for (genvar k = 0; k < NSIZES; k++) begin : g_mask
    localparam int unsigned W = BYTE_W << k;
    if (W >= DATA_W) begin : g_full
      assign mask_a[k] = '1;
    end else begin : g_part
      assign mask_a[k] = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
    end
  end

  logic [DATA_W-1:0] op_mask, dst_mask, top_bit, ext, smax, smin, clamp;
  logic              sign;

  always_comb begin
    op_mask  = mask_a[op_sz];
    dst_mask = mask_a[dst_sz];
    top_bit  = op_mask & ~(op_mask >> 1);
    sign     = |(val & top_bit);
    ext      = (sat_sgn && sign) ? (val | ~op_mask) : val;
    smax     = dst_mask >> 1;
    smin     = ~smax;
    clamp    = val;
    if (sat_en) begin
      if (!sat_sgn) begin
        clamp = (val > dst_mask) ? dst_mask : val;
      end else if ($signed(ext) > $signed(smax)) begin
        clamp = smax;
      end else if ($signed(ext) < $signed(smin)) begin
        clamp = smin;
      end else begin
        clamp = ext;
      end
    end
    res = clamp & dst_mask;
  end
endmodule

// File: rtl/ldconv_unit.sv
module ldconv_unit #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SZ_W   = $clog2(ldconv_pkg::num_sizes(DATA_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [SZ_W-1:0]   op_size,
  input  logic              byte_rev,
  input  logic              little_endian,
  input  logic [SZ_W-1:0]   dst_size,
  input  logic [SZ_W-1:0]   mem_size,
  input  logic              sat_en,
  input  logic              sat_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_undef
);
  logic              do_swap;
  logic [DATA_W-1:0] ordered;
  logic [DATA_W-1:0] fitted;
  logic              undef_c;

  assign do_swap = ~(byte_rev ^ little_endian);
  assign undef_c = (mem_size < op_size);

  ldconv_swap #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_swap (
    .raw     (raw_data),
    .op_sz   (op_size),
    .do_swap (do_swap),
    .val     (ordered)
  );

  ldconv_narrow #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_narrow (
    .val     (ordered),
    .op_sz   (op_size),
    .dst_sz  (dst_size),
    .sat_en  (sat_en),
    .sat_sgn (sat_signed),
    .res     (fitted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= fitted;
        out_undef <= undef_c;
      end
    end
  end
endmodule

// File: rtl/ldconv_checks.sv
module ldconv_checks #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SZ_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] raw_data,
  input logic [SZ_W-1:0]   op_size,
  input logic              byte_rev,
  input logic              little_endian,
  input logic [SZ_W-1:0]   dst_size,
  input logic [SZ_W-1:0]   mem_size,
  input logic              sat_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_undef
);
  localparam int unsigned MAXC = (1 << SZ_W) - 1;
  logic [DATA_W-1:0] dmask;
  always_comb begin
    dmask = '1;
    for (int k = 0; k < MAXC; k++) begin
      if (dst_size == SZ_W'(k)) dmask = DATA_W'((DATA_W'(1) << (8 << k)) - 1);
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en && (byte_rev != little_endian)) |=> (out_data[7:0] == $past(raw_data[7:0]))); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_data & ~$past(dmask)) == '0)); // R4
  AST_UNDEF_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_undef == ($past(mem_size) < $past(op_size)))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_undef))); // R9
endmodule

bind ldconv_unit ldconv_checks #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_checks (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .raw_data      (raw_data),
  .op_size       (op_size),
  .byte_rev      (byte_rev),
  .little_endian (little_endian),
  .dst_size      (dst_size),
  .mem_size      (mem_size),
  .sat_en        (sat_en),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_undef     (out_undef)
);

// File: tb/ldconv_unit_test.sv
`timescale 1ns/1ps
module ldconv_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] raw_data = '0;
  logic [1:0]  op_size = '0, dst_size = '0, mem_size = 2'd3;
  logic        byte_rev = 1'b0, little_endian = 1'b1, sat_en = 1'b0, sat_signed = 1'b0;
  logic        out_valid, out_undef;
  logic [63:0] out_data;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ldconv_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_data(raw_data),
    .op_size(op_size), .byte_rev(byte_rev), .little_endian(little_endian),
    .dst_size(dst_size), .mem_size(mem_size), .sat_en(sat_en),
    .sat_signed(sat_signed), .out_valid(out_valid), .out_data(out_data),
    .out_undef(out_undef)
  );

  // fields: op dst mem rev le sat sgn | raw | expected | undef
  localparam int NV = 20;
  localparam logic [138:0] VEC [NV] = '{
    {2'd3,2'd3,2'd3,1'b0,1'b1,1'b0,1'b0, 64'h1122334455667788, 64'h1122334455667788, 1'b0}, // R2 full
    {2'd1,2'd3,2'd3,1'b0,1'b1,1'b0,1'b0, 64'h1122334455667788, 64'h0000000000007788, 1'b0}, // R2 half
    {2'd1,2'd3,2'd3,1'b1,1'b1,1'b0,1'b0, 64'h1122334455667788, 64'h0000000000008877, 1'b0}, // R3
    {2'd2,2'd3,2'd2,1'b0,1'b0,1'b0,1'b0, 64'h1122334455667788, 64'h0000000088776655, 1'b0}, // R3
    {2'd3,2'd3,2'd3,1'b1,1'b1,1'b0,1'b0, 64'h1122334455667788, 64'h8877665544332211, 1'b0}, // R3
    {2'd3,2'd0,2'd3,1'b0,1'b1,1'b0,1'b0, 64'h1122334455667788, 64'h0000000000000088, 1'b0}, // R4
    {2'd0,2'd2,2'd3,1'b0,1'b1,1'b0,1'b0, 64'hABABABABABABABFF, 64'h00000000000000FF, 1'b0}, // R4
    {2'd2,2'd0,2'd3,1'b0,1'b1,1'b1,1'b0, 64'h0000000000000123, 64'h00000000000000FF, 1'b0}, // R5
    {2'd2,2'd0,2'd3,1'b0,1'b1,1'b1,1'b0, 64'h000000000000007F, 64'h000000000000007F, 1'b0}, // R5
    {2'd1,2'd0,2'd3,1'b0,1'b1,1'b1,1'b1, 64'h0000000000000200, 64'h000000000000007F, 1'b0}, // R6
    {2'd1,2'd0,2'd3,1'b0,1'b1,1'b1,1'b1, 64'h000000000000FE00, 64'h0000000000000080, 1'b0}, // R6
    {2'd1,2'd0,2'd3,1'b0,1'b1,1'b1,1'b1, 64'h000000000000FFF0, 64'h00000000000000F0, 1'b0}, // R6
    {2'd0,2'd1,2'd3,1'b0,1'b1,1'b1,1'b1, 64'h0000000000000085, 64'h000000000000FF85, 1'b0}, // R7
    {2'd0,2'd2,2'd3,1'b0,1'b1,1'b1,1'b0, 64'h0000000000000085, 64'h0000000000000085, 1'b0}, // R7
    {2'd2,2'd3,2'd3,1'b0,1'b1,1'b1,1'b1, 64'h0000000080000000, 64'hFFFFFFFF80000000, 1'b0}, // R7
    {2'd1,2'd0,2'd3,1'b1,1'b1,1'b1,1'b1, 64'h00000000000000FF, 64'h0000000000000080, 1'b0}, // R3 R6
    {2'd3,2'd2,2'd3,1'b0,1'b1,1'b1,1'b0, 64'h0000000100000000, 64'h00000000FFFFFFFF, 1'b0}, // R5
    {2'd1,2'd3,2'd0,1'b0,1'b1,1'b0,1'b0, 64'h0000000000001234, 64'h0000000000001234, 1'b1}, // R8
    {2'd3,2'd1,2'd3,1'b0,1'b1,1'b1,1'b1, 64'hFFFFFFFFFFFF8000, 64'h0000000000008000, 1'b0}, // R6 on min
    {2'd3,2'd1,2'd3,1'b0,1'b1,1'b1,1'b1, 64'hFFFFFFFFFFFF7FFF, 64'h0000000000008000, 1'b0}  // R6 below min
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [138:0] v);
    @(negedge clk);
    {op_size, dst_size, mem_size, byte_rev, little_endian, sat_en, sat_signed} = v[138:129];
    raw_data = v[128:65];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    chk("R1 reset data", out_data, 64'd0);
    chk("R1 reset undef", 64'(out_undef), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle valid", 64'(out_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      chk($sformatf("R1 valid vec%0d", i), 64'(out_valid), 64'd1);
      chk($sformatf("data vec%0d (R2-R8)", i), out_data, VEC[i][64:1]);
      chk($sformatf("R8 undef vec%0d", i), 64'(out_undef), 64'(VEC[i][0]));
    end

    // R1 valid drops one cycle after the request
    @(negedge clk);
    chk("R1 valid low", 64'(out_valid), 64'd0);

    // R9 hold: change inputs while idle, outputs keep the last result
    raw_data = 64'hDEADBEEFCAFEF00D;
    mem_size = 2'd0;
    op_size  = 2'd3;
    repeat (2) @(negedge clk);
    chk("R9 hold data", out_data, 64'h0000000000008000);
    chk("R9 hold undef", 64'(out_undef), 64'd0);

    // R2 upper bytes ignored: two raws differing only above the access size
    issue({2'd0,2'd3,2'd3,1'b0,1'b1,1'b0,1'b0, 64'h00000000000000A5, 64'h0, 1'b0});
    chk("R2 upper ignored a", out_data, 64'h00000000000000A5);
    issue({2'd0,2'd3,2'd3,1'b0,1'b1,1'b0,1'b0, 64'hFFFFFFFFFFFFFFA5, 64'h0, 1'b0});
    chk("R2 upper ignored b", out_data, 64'h00000000000000A5);

    // R8 equal widths are defined
    issue({2'd2,2'd2,2'd2,1'b0,1'b1,1'b0,1'b0, 64'h0000000012345678, 64'h0, 1'b0});
    chk("R8 equal not undef", 64'(out_undef), 64'd0);
    chk("R4 equal width data", out_data, 64'h0000000012345678);

    // R1 reset clears a live result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears data", out_data, 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule